// File: doc/BRIEF.md
# Mask-Driven Vector Compress/Expand Unit

This unit rearranges the elements of a fixed-size vector under the control of a per-element mask bit. In compress mode the elements whose mask bit is set are gathered and placed one after another, starting at result slot 0, in ascending source order. In expand mode the operation runs the other way. Consecutive source elements, taken from element 0 upward, are placed into the slots whose mask bit is set. The other slots keep the value of a supplied old destination vector. In both modes the unit reports a packed length. This is the number of set mask bits, which is the count of elements taken from or written to the packed side.

The unit is sequential and visits one mask position per clock. A start pulse captures the operands and the mode. After a fixed number of cycles a one-cycle done pulse marks that the result vector and the packed length are final. Both outputs then stay unchanged until the next operation is accepted. A start that arrives while an operation is running is ignored.

Top module: `vec_pack_unit`

## Requirements
- R1: In compress mode (mode = 0), the element at the j-th set mask position (counting from bit 0 upward) appears in result slot j. For example, mask bits 1, 4, 5, 7 give slots 0..3 = source elements 1, 4, 5, 7.
- R2: In compress mode, every result slot whose index is at or above the packed length reads zero.
- R3: When done is high, packed_len equals the number of set bits in the captured mask. Its range is 0 to NUM_EL.
- R4: In expand mode (mode = 1), source element k is written to the slot of the k-th set mask bit (k counted from 0).
- R5: In expand mode, every slot whose mask bit is clear holds the corresponding element of old_vec.
- R6: An all-zero mask gives packed_len 0. In that case compress yields an all-zero result and expand yields old_vec unchanged.
- R7: An all-ones mask makes both compress and expand return the source vector unchanged, with packed_len = NUM_EL.
- R8: done is high for exactly one cycle. It rises NUM_EL clock edges after the edge that accepts start.
- R9: result and packed_len do not change from done until the next accepted start. A start pulse while busy is high is ignored and does not alter that operation's outcome.
- R10: After reset, busy and done are low and result and packed_len are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| mode | input | 1 | 0 = compress, 1 = expand |
| src_vec | input | NUM_EL*EL_W | Source elements, element i at bits [i*EL_W +: EL_W] |
| mask | input | NUM_EL | Mask, bit i governs position i |
| old_vec | input | NUM_EL*EL_W | Old destination vector used by expand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | NUM_EL*EL_W | Result vector, same element layout as src_vec |
| packed_len | output | CNT_W | Number of set mask bits (0..NUM_EL) |

## Verification
The bench aims at masks whose set bits sit at both ends (bit 0 and bit NUM_EL-1), the empty mask and the full mask. A design with an off-by-one in the write pointer would then drop the last element or spill past the packed length. Compress results are also checked for zeros in the tail slots, so a design that left stale or source data there would be caught. In expand mode the clear-mask slots are compared against old_vec, which exposes any design that zeroes them or reads from the wrong source index. A start pulse injected during a run, with different operands, and input changes made after done show whether the unit corrupts a running operation or fails to hold its outputs.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
   typedef enum logic {
      VCX_COMPRESS = 1'b0,
      VCX_EXPAND   = 1'b1
   } vcx_mode_e;
endpackage

// File: rtl/vcx_seq_ctrl.sv
module vcx_seq_ctrl #(
   parameter int NUM_EL = 8,
   parameter int IDX_W  = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             accept,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_EL - 1);

   logic last;

   assign accept = start && !busy;
   assign last   = (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         idx  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
               idx  <= '0;
            end else begin
               idx <= idx + IDX_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/vcx_step.sv
module vcx_step
   import vcx_pkg::*;
#(
   parameter int NUM_EL = 8,
   parameter int EL_W   = 16,
   parameter int IDX_W  = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
   parameter int CNT_W  = $clog2(NUM_EL + 1),
   parameter int NB     = NUM_EL * EL_W
) (
   input  vcx_mode_e        mode,
   input  logic             mbit,
   input  logic [IDX_W-1:0] idx,
   input  logic [CNT_W-1:0] k_in,
   input  logic [NB-1:0]    src,
   input  logic [NB-1:0]    res_in,
   output logic [NB-1:0]    res_out,
   output logic [CNT_W-1:0] k_out
);
   always_comb begin
      res_out = res_in;
      k_out   = k_in;
      if (mbit) begin
         k_out = k_in + CNT_W'(1);
         if (mode == VCX_EXPAND)
            res_out[int'(idx)*EL_W +: EL_W] = src[int'(k_in)*EL_W +: EL_W];
         else
            res_out[int'(k_in)*EL_W +: EL_W] = src[int'(idx)*EL_W +: EL_W];
      end
   end
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit
   import vcx_pkg::*;
#(
   parameter int NUM_EL = 8,
   parameter int EL_W   = 16,
   parameter int CNT_W  = $clog2(NUM_EL + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   mode,
   input  logic [NUM_EL*EL_W-1:0] src_vec,
   input  logic [NUM_EL-1:0]      mask,
   input  logic [NUM_EL*EL_W-1:0] old_vec,
   output logic                   busy,
   output logic                   done,
   output logic [NUM_EL*EL_W-1:0] result,
   output logic [CNT_W-1:0]       packed_len
);
   localparam int NB    = NUM_EL * EL_W;
   localparam int IDX_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1;

   if (NUM_EL < 2) begin : g_bad_num_el
      $error("vec_pack_unit: NUM_EL must be at least 2");
   end
   if (EL_W < 1) begin : g_bad_el_w
      $error("vec_pack_unit: EL_W must be positive");
   end
   if (CNT_W < $clog2(NUM_EL + 1)) begin : g_bad_cnt_w
      $error("vec_pack_unit: CNT_W too narrow for packed length");
   end

   logic             accept;
   logic [IDX_W-1:0] idx;
   vcx_mode_e        mode_q;
   logic [NUM_EL-1:0] mask_q;
   logic [NB-1:0]    src_q;
   logic [NB-1:0]    res_q;
   logic [NB-1:0]    res_n;
   logic [CNT_W-1:0] k_q;
   logic [CNT_W-1:0] k_n;

   vcx_seq_ctrl #(.NUM_EL(NUM_EL), .IDX_W(IDX_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .busy   (busy),
      .done   (done),
      .accept (accept),
      .idx    (idx)
   );

   vcx_step #(
      .NUM_EL(NUM_EL), .EL_W(EL_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .NB(NB)
   ) u_step (
      .mode    (mode_q),
      .mbit    (mask_q[idx]),
      .idx     (idx),
      .k_in    (k_q),
      .src     (src_q),
      .res_in  (res_q),
      .res_out (res_n),
      .k_out   (k_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= VCX_COMPRESS;
         mask_q <= '0;
         src_q  <= '0;
         res_q  <= '0;
         k_q    <= '0;
      end else if (accept) begin
         mode_q <= vcx_mode_e'(mode);
         mask_q <= mask;
         src_q  <= src_vec;
         res_q  <= mode ? old_vec : '0;
         k_q    <= '0;
      end else if (busy) begin
         res_q <= res_n;
         k_q   <= k_n;
      end
   end

   assign result     = res_q;
   assign packed_len = k_q;
endmodule

// File: rtl/vcx_chk.sv
module vcx_chk #(
   parameter int NUM_EL = 8,
   parameter int EL_W   = 16,
   parameter int CNT_W  = $clog2(NUM_EL + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start,
   input logic                   mode,
   input logic [NUM_EL-1:0]      mask,
   input logic [NUM_EL*EL_W-1:0] old_vec,
   input logic                   busy,
   input logic                   done,
   input logic [NUM_EL*EL_W-1:0] result,
   input logic [CNT_W-1:0]       packed_len
);
   localparam int NB    = NUM_EL * EL_W;
   localparam int CYC_W = $clog2(NUM_EL + 2) + 1;

   logic [NUM_EL-1:0] m_cap;
   logic [NB-1:0]     old_cap;
   logic              mode_cap;
   logic [CYC_W-1:0]  cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cap    <= '0;
         old_cap  <= '0;
         mode_cap <= 1'b0;
         cyc      <= '0;
      end else if (start && !busy) begin
         m_cap    <= mask;
         old_cap  <= old_vec;
         mode_cap <= mode;
         cyc      <= '0;
      end else if (busy) begin
         cyc <= cyc + CYC_W'(1);
      end
   end

   function automatic logic tail_zero(input logic [NB-1:0] r, input logic [CNT_W-1:0] n);
      for (int i = 0; i < NUM_EL; i++)
         if (i >= int'(n) && r[i*EL_W +: EL_W] != '0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic keeps_old(input logic [NB-1:0] r, input logic [NB-1:0] o,
                                      input logic [NUM_EL-1:0] m);
      for (int i = 0; i < NUM_EL; i++)
         if (!m[i] && r[i*EL_W +: EL_W] != o[i*EL_W +: EL_W]) return 1'b0;
      return 1'b1;
   endfunction

   p_tail_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_cap) |-> tail_zero(result, packed_len));

   p_len_popcount_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (packed_len == CNT_W'($countones(m_cap))));

   p_expand_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_cap) |-> keeps_old(result, old_cap, m_cap));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc == CYC_W'(NUM_EL)));

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(result) && $stable(packed_len)));

   p_busy_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind vec_pack_unit vcx_chk #(.NUM_EL(NUM_EL), .EL_W(EL_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .mask       (mask),
   .old_vec    (old_vec),
   .busy       (busy),
   .done       (done),
   .result     (result),
   .packed_len (packed_len)
);

// File: tb/sim_vec_pack_unit.sv
module sim_vec_pack_unit;
   localparam int NUM_EL = 8;
   localparam int EL_W   = 16;
   localparam int CNT_W  = $clog2(NUM_EL + 1);
   localparam int NB     = NUM_EL * EL_W;

   typedef struct {
      logic [NB-1:0]    res;
      logic [CNT_W-1:0] len;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             mode = 1'b0;
   logic [NB-1:0]    src_vec = '0;
   logic [NUM_EL-1:0] mask = '0;
   logic [NB-1:0]    old_vec = '0;
   logic             busy;
   logic             done;
   logic [NB-1:0]    result;
   logic [CNT_W-1:0] packed_len;

   int   checks = 0;
   int   errors = 0;
   exp_t sb_q[$];
   exp_t last_exp;

   always #2 clk = ~clk;

   vec_pack_unit #(.NUM_EL(NUM_EL), .EL_W(EL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .src_vec(src_vec),
      .mask(mask), .old_vec(old_vec), .busy(busy), .done(done),
      .result(result), .packed_len(packed_len)
   );

   task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic md, input logic [NB-1:0] s,
                                  input logic [NUM_EL-1:0] m, input logic [NB-1:0] o,
                                  input string tag);
      exp_t e;
      int   k = 0;
      e.res = md ? o : '0;
      for (int i = 0; i < NUM_EL; i++) begin
         if (m[i]) begin
            if (md) e.res[i*EL_W +: EL_W] = s[k*EL_W +: EL_W];
            else    e.res[k*EL_W +: EL_W] = s[i*EL_W +: EL_W];
            k++;
         end
      end
      e.len = CNT_W'(k);
      e.tag = tag;
      return e;
   endfunction

   // Monitor: pops the scoreboard on each done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R8 unexpected done actual=1 expected=0");
         end else begin
            last_exp = sb_q.pop_front();
            chk({last_exp.tag, " result"}, result, last_exp.res);
            chk({last_exp.tag, " R3 len"}, NB'(packed_len), NB'(last_exp.len));
         end
      end
   end

   // Driver: optional glitch start while busy (R9)
   task automatic run(input logic md, input logic [NB-1:0] s, input logic [NUM_EL-1:0] m,
                      input logic [NB-1:0] o, input string tag, input bit glitch = 0);
      int cnt = 0;
      sb_q.push_back(model(md, s, m, o, tag));
      @(negedge clk);
      mode = md; src_vec = s; mask = m; old_vec = o; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      do begin
         @(negedge clk);
         cnt++;
         if (glitch && cnt == 3) begin
            start = 1'b1; mode = ~md; mask = ~m; src_vec = ~s; old_vec = ~o;
         end else begin
            start = 1'b0;
         end
      end while (!done && cnt < 40);
      chk("R8 latency", NB'(cnt), NB'(NUM_EL));
      @(negedge clk);
      chk("R8 done one cycle", NB'(done), NB'(0));
   endtask

   function automatic logic [NB-1:0] pattern(input int seed);
      logic [NB-1:0] v;
      for (int i = 0; i < NUM_EL; i++) v[i*EL_W +: EL_W] = EL_W'(seed * 1021 + i * 257 + 17);
      return v;
   endfunction

   initial begin : watchdog
      #400000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [NB-1:0] a, b;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy", NB'(busy), '0);
      chk("R10 done", NB'(done), '0);
      chk("R10 result", result, '0);
      chk("R10 len", NB'(packed_len), '0);
      rst_n = 1'b1;
      a = pattern(1); b = pattern(2);
      run(1'b0, a, 8'b1011_0010, b, "R1 R2 compress 1,4,5,7");
      run(1'b1, a, 8'b1011_0010, b, "R4 R5 expand 1,4,5,7");
      run(1'b0, a, 8'b1000_0001, b, "R1 R2 compress ends");
      run(1'b1, a, 8'b1000_0001, b, "R4 R5 expand ends");
      run(1'b0, a, 8'h00, b, "R6 compress empty");
      run(1'b1, a, 8'h00, b, "R6 expand empty");
      run(1'b0, a, 8'hFF, b, "R7 compress full");
      chk("R7 compress identity", result, a);
      run(1'b1, a, 8'hFF, b, "R7 expand full");
      chk("R7 expand identity", result, a);
      for (int t = 0; t < 20; t++)
         run(t[0], pattern(t + 5), NUM_EL'(t * 37 + 11), pattern(t + 99), "R1 R4 mixed");
      // R9: start while busy is ignored
      run(1'b0, a, 8'b0110_1100, b, "R9 glitch compress", 1'b1);
      run(1'b1, a, 8'b0101_0011, b, "R9 glitch expand", 1'b1);
      // R9: outputs hold after done while inputs move
      mode = 1'b1; mask = 8'hA5; src_vec = pattern(77); old_vec = pattern(78);
      repeat (4) @(negedge clk);
      chk("R9 hold result", result, last_exp.res);
      chk("R9 hold len", NB'(packed_len), NB'(last_exp.len));
      chk("R9 scoreboard drained", NB'(sb_q.size()), '0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule